// File: doc/BRIEF.md
# BCD calendar clock with alarm

This block keeps time of day and a calendar in binary-coded decimal. It counts seconds, minutes, hours (24-hour only), day of week, day of month, month, a two-digit year and a separate century byte. A strobe from a 32.768 kHz reference is divided by a parameterised prescaler into one advance per second. The calendar follows month lengths and leap years, and a year wrap from 99 to 00 carries into the century.

A host reads and writes every field through a byte-wide register port. Each time field has its own address. Four alarm bytes watch seconds, minutes, hours and day of month. Every alarm byte carries an ignore bit, so the alarm can fire once at an exact moment or repeat every second, minute, hour or day. A write to a time field replaces it on the next clock edge and restarts the prescaler, so the next advance comes a full second after the write.

Top module: `bcd_rtc_core`

## Requirements
- R1: Address 0 holds seconds, address 1 minutes and address 2 hours, all in BCD. Seconds and minutes go from 59 to 00 and carry on. Hours go from 23 to 00 and carry into the date.
- R2: Address 3 holds the day of week, 01 to 07. At each midnight it goes from 07 to 01, or otherwise up by one, whatever the date does.
- R3: Address 4 holds the day of month, address 5 the month and address 6 the year, all in BCD. After the last day of a month the date returns to 01 and the month steps up. Months 04, 06, 09 and 11 have 30 days; every other month except February has 31. Month 12 wraps to 01 and steps the year up.
- R4: February has 29 days when the full year (century × 100 + year) is a leap year and 28 days otherwise. A leap year divides by 4, and a year ending in 00 is a leap year only when it divides by 400.
- R5: Address 7 holds the century in BCD. It steps up by one when the year wraps from 99 to 00, and it wraps from 99 to 00.
- R6: The time advances by one second on every PRESCALE-th cycle with `ref_en` high, counted from reset or from the last time write. Between advances no time field changes.
- R7: A write with `wr_en` high stores `wdata` at `addr` on that clock edge. `rdata` shows the register at `addr` combinationally. Addresses 12 to 15 read 0. A write to addresses 0 to 7 restarts the prescaler and cancels any advance due in that cycle. A write to addresses 8 to 11 does not affect the prescaler.
- R8: Addresses 8, 9, 10 and 11 configure the alarm on seconds, minutes, hours and day of month. Bit 7 set makes the field ignored, and bits 6:0 hold the BCD value to compare. In the cycle right after an advance, `alarm_hit` is high for exactly one cycle if every field that is not ignored equals the new time.
- R9: With every field ignored the alarm fires once per second. With only seconds compared it fires once per minute. An alarm write alone never raises `alarm_hit`.
- R10: After reset the time reads 00:00:00 with day of week 01, date 01, month 01, year 00 and century 20. All alarm bytes read 00, and `alarm_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle strobe per reference oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| alarm_hit | output | 1 | One-cycle pulse when the new time matches the alarm |

## Verification
The advance is registered on the rising edge where the PRESCALE-th counted strobe is seen. The updated time fields and the `alarm_hit` pulse both appear in the cycle after that edge, and a host write shows up in `rdata` in the cycle after its edge. The bench drives inputs just after each falling edge. It updates its behavioural calendar right after the rising edge and compares `rdata` and `alarm_hit` at the following falling edge, so each result is checked in the very cycle it is due. The read address rotates across all registers while the model runs, and targeted reads pin down month ends, leap days, the century carry and the alarm counts.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

   typedef struct packed {
      logic [7:0] cen;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] mday;
      logic [7:0] wday;
      logic [7:0] hr;
      logic [7:0] mn;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int N_TIME_REGS = 8;
   localparam int N_ALM_REGS  = 4;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return v + 8'd1;
   endfunction

   function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
      return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
   endfunction

   function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
      logic [6:0] b;
      b = (yr == 8'h00) ? bcd_to_bin(cen) : bcd_to_bin(yr);
      return b[1:0] == 2'b00;
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   input  logic restart,
   output logic tick
);
   localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("rtc_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   assign tick = ref_en && !restart && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (ref_en)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
   import bcd_rtc_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            wr_en,
   input  logic [2:0]      wr_sel,
   input  logic [7:0]      wdata,
   output rtc_time_t       now,
   output logic [3:0][7:0] nxt_cmp
);
   rtc_time_t now_q, nxt, wv;
   logic      leap;

   always_comb begin
      nxt  = now_q;
      leap = is_leap(now_q.yr, now_q.cen);
      if (now_q.sec != 8'h59) nxt.sec = bcd_inc(now_q.sec);
      else begin
         nxt.sec = 8'h00;
         if (now_q.mn != 8'h59) nxt.mn = bcd_inc(now_q.mn);
         else begin
            nxt.mn = 8'h00;
            if (now_q.hr != 8'h23) nxt.hr = bcd_inc(now_q.hr);
            else begin
               nxt.hr   = 8'h00;
               nxt.wday = (now_q.wday >= 8'h07) ? 8'h01 : bcd_inc(now_q.wday);
               if (now_q.mday != month_last(now_q.mon, leap)) nxt.mday = bcd_inc(now_q.mday);
               else begin
                  nxt.mday = 8'h01;
                  if (now_q.mon != 8'h12) nxt.mon = bcd_inc(now_q.mon);
                  else begin
                     nxt.mon = 8'h01;
                     if (now_q.yr != 8'h99) nxt.yr = bcd_inc(now_q.yr);
                     else begin
                        nxt.yr  = 8'h00;
                        nxt.cen = (now_q.cen == 8'h99) ? 8'h00 : bcd_inc(now_q.cen);
                     end
                  end
               end
            end
         end
      end
   end

   always_comb begin
      wv = now_q;
      case (wr_sel)
         3'd0: wv.sec  = wdata;
         3'd1: wv.mn   = wdata;
         3'd2: wv.hr   = wdata;
         3'd3: wv.wday = wdata;
         3'd4: wv.mday = wdata;
         3'd5: wv.mon  = wdata;
         3'd6: wv.yr   = wdata;
         default: wv.cen = wdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now_q <= '{cen: 8'h20, yr: 8'h00, mon: 8'h01, mday: 8'h01,
                    wday: 8'h01, hr: 8'h00, mn: 8'h00, sec: 8'h00};
      end else if (wr_en) begin
         now_q <= wv;
      end else if (tick) begin
         now_q <= nxt;
      end
   end

   assign now     = now_q;
   assign nxt_cmp = {nxt.mday, nxt.hr, nxt.mn, nxt.sec};
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
   parameter int N_FIELDS = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic [N_FIELDS-1:0][7:0] cfg,
   input  logic [N_FIELDS-1:0][7:0] fld,
   output logic                     hit
);
   logic [N_FIELDS-1:0] fld_ok;

   generate
      for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
         assign fld_ok[i] = cfg[i][7] || ({1'b0, cfg[i][6:0]} == fld[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= tick && (&fld_ok);
   end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
   import bcd_rtc_pkg::*;
#(
   parameter int PRESCALE = 32768,
   parameter int ADDR_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic              alarm_hit
);
   localparam int ALM_BASE = N_TIME_REGS;
   localparam int ALM_END  = N_TIME_REGS + N_ALM_REGS;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("bcd_rtc_core: ADDR_W must be at least 4");
      end
   endgenerate

   logic                        time_wr, alm_wr, tick;
   rtc_time_t                   cal_now;
   logic [3:0][7:0]             cal_nxt;
   logic [N_ALM_REGS-1:0][7:0]  alm_q;
   logic [N_TIME_REGS-1:0][7:0] tv;

   assign time_wr = wr_en && (addr < ADDR_W'(ALM_BASE));
   assign alm_wr  = wr_en && (addr >= ADDR_W'(ALM_BASE)) && (addr < ADDR_W'(ALM_END));

   rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(time_wr), .tick(tick)
   );

   rtc_calendar u_cal (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(time_wr),
      .wr_sel(addr[2:0]), .wdata(wdata), .now(cal_now), .nxt_cmp(cal_nxt)
   );

   generate
      for (genvar i = 0; i < N_ALM_REGS; i++) begin : g_alm
         always_ff @(posedge clk) begin
            if (!rst_n)                            alm_q[i] <= 8'h00;
            else if (alm_wr && addr[1:0] == 2'(i)) alm_q[i] <= wdata;
         end
      end
   endgenerate

   rtc_alarm #(.N_FIELDS(N_ALM_REGS)) u_alarm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(alm_q), .fld(cal_nxt), .hit(alarm_hit)
   );

   assign tv = cal_now;

   always_comb begin
      if (addr < ADDR_W'(ALM_BASE))     rdata = tv[addr[2:0]];
      else if (addr < ADDR_W'(ALM_END)) rdata = alm_q[addr[1:0]];
      else                              rdata = 8'h00;
   end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
   import bcd_rtc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic              tick,
   input rtc_time_t         now,
   input logic              alarm_hit
);
   logic time_wr;
   logic last_sec;
   assign time_wr  = wr_en && (addr < ADDR_W'(N_TIME_REGS));
   assign last_sec = (now.hr == 8'h23) && (now.mn == 8'h59) && (now.sec == 8'h59);

   AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && now.sec == 8'h59) |=> (now.sec == 8'h00)); // R1

   AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && last_sec && now.wday == 8'h07) |=> (now.wday == 8'h01)); // R2

   AST_CENTURY_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && last_sec && now.yr == 8'h99 && now.mon == 8'h12 && now.mday == 8'h31)
      |=> (now.yr == 8'h00 && now.cen != $past(now.cen))); // R5

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R6

   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !time_wr) |=> $stable(now)); // R6

   AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr |=> !tick); // R7

   AST_ALARM_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |-> $past(tick)); // R8
endmodule

bind bcd_rtc_core bcd_rtc_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .tick(tick), .now(cal_now), .alarm_hit(alarm_hit)
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
   localparam int P = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       alarm_hit;

   always #2 clk = ~clk;

   bcd_rtc_core #(.PRESCALE(P), .ADDR_W(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_hit(alarm_hit)
   );

   int n_tests = 0, n_fail = 0;
   int m_sec = 0, m_min = 0, m_hr = 0, m_wd = 1, m_md = 1, m_mo = 1, m_yr = 0, m_cc = 20;
   int m_alm [4] = '{0, 0, 0, 0};
   int pcnt = 0, rd_idx = 0, hit_cnt = 0;
   bit exp_hit = 0;
   logic [15:0] lfsr = 16'hACE1;

   function automatic int bcd(int v);
      return (v / 10) * 16 + (v % 10);
   endfunction

   function automatic int unbcd(int b);
      return (b / 16) * 10 + (b % 16);
   endfunction

   function automatic int dim(int mo, int yr, int cc);
      int full;
      full = cc * 100 + yr;
      if (mo == 2)
         return (((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0)) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic int m_reg(int a);
      case (a)
         0: return bcd(m_sec);
         1: return bcd(m_min);
         2: return bcd(m_hr);
         3: return bcd(m_wd);
         4: return bcd(m_md);
         5: return bcd(m_mo);
         6: return bcd(m_yr);
         7: return bcd(m_cc);
         8, 9, 10, 11: return m_alm[a-8];
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(int a);
      if (a <= 2) return "R1";
      if (a == 3) return "R2";
      if (a <= 6) return "R3";
      if (a == 7) return "R5";
      return "R7";
   endfunction

   function automatic bit m_match();
      int f [4];
      f[0] = bcd(m_sec); f[1] = bcd(m_min); f[2] = bcd(m_hr); f[3] = bcd(m_md);
      for (int i = 0; i < 4; i++)
         if (((m_alm[i] & 8'h80) == 0) && ((m_alm[i] & 8'h7F) != f[i])) return 0;
      return 1;
   endfunction

   task automatic m_advance();
      m_sec++;
      if (m_sec == 60) begin
         m_sec = 0; m_min++;
         if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin
               m_hr = 0;
               m_wd = (m_wd == 7) ? 1 : m_wd + 1;
               if (m_md == dim(m_mo, m_yr, m_cc)) begin
                  m_md = 1;
                  if (m_mo == 12) begin
                     m_mo = 1;
                     if (m_yr == 99) begin m_yr = 0; m_cc = (m_cc + 1) % 100; end
                     else m_yr++;
                  end else m_mo++;
               end else m_md++;
            end
         end
      end
   endtask

   task automatic check(string tag, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // One cycle: drive after the falling edge, update the model after the
   // rising edge, compare at the next falling edge.
   task automatic step(bit re, bit we, int a, int d);
      bit tk;
      ref_en = re; wr_en = we; addr = 4'(a); wdata = 8'(d);
      @(posedge clk);
      tk = 0;
      if (we && a < 8) begin
         case (a)
            0: m_sec = unbcd(d);
            1: m_min = unbcd(d);
            2: m_hr  = unbcd(d);
            3: m_wd  = unbcd(d);
            4: m_md  = unbcd(d);
            5: m_mo  = unbcd(d);
            6: m_yr  = unbcd(d);
            default: m_cc = unbcd(d);
         endcase
         pcnt = 0;
      end else if (re) begin
         if (pcnt == P - 1) begin tk = 1; pcnt = 0; end
         else pcnt++;
      end
      if (tk) m_advance();
      exp_hit = tk && m_match();
      if (we && a >= 8 && a < 12) m_alm[a-8] = d;
      @(negedge clk);
      check(tag_of(a), int'(rdata), m_reg(a));
      check("R8", int'(alarm_hit), int'(exp_hit));
      if (alarm_hit) hit_cnt++;
   endtask

   task automatic run(int n, bit irregular);
      for (int i = 0; i < n; i++) begin
         bit re;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         re = irregular ? (lfsr[0] | lfsr[3]) : 1'b1;
         step(re, 0, rd_idx, 0);
         rd_idx = (rd_idx + 1) % 13;
      end
   endtask

   task automatic rd(int a, output int v);
      step(0, 0, a, 0);
      v = int'(rdata);
   endtask

   task automatic set_time(int cc, int yy, int mo, int md, int wd, int hh, int mi, int ss);
      step(1, 1, 7, bcd(cc)); step(1, 1, 6, bcd(yy)); step(1, 1, 5, bcd(mo));
      step(1, 1, 4, bcd(md)); step(1, 1, 3, bcd(wd)); step(1, 1, 2, bcd(hh));
      step(1, 1, 1, bcd(mi)); step(1, 1, 0, bcd(ss));
   endtask

   task automatic day_roll(string tag, int cc, int yy, int mo, int md, int emd, int emo);
      int v;
      set_time(cc, yy, mo, md, 3, 23, 59, 59);
      run(P, 0);
      rd(4, v); check(tag, v, bcd(emd));
      rd(5, v); check(tag, v, bcd(emo));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset values
      begin
         int rv [12] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20,
                         8'h00, 8'h00, 8'h00, 8'h00};
         for (int a = 0; a < 12; a++) begin
            rd(a, v); check("R10", v, rv[a]);
         end
         check("R10", int'(alarm_hit), 0);
      end

      // R6/R7: write restarts the prescaler; advance comes P pulses later
      step(1, 0, 0, 0); step(1, 0, 0, 0);
      step(1, 1, 0, 8'h10);
      for (int i = 0; i < P - 1; i++) step(1, 0, 0, 0);
      check("R7", int'(rdata), 8'h10);
      step(1, 0, 0, 0);
      check("R6", int'(rdata), 8'h11);
      rd(12, v); check("R7", v, 0);

      // R1: free run with an irregular reference strobe
      set_time(20, 23, 6, 15, 4, 22, 58, 30);
      run(3000, 1);

      // R3: every month end in a non-leap year
      for (int mo = 1; mo <= 12; mo++)
         day_roll("R3", 20, 23, mo, dim(mo, 23, 20), 1, (mo == 12) ? 1 : mo + 1);
      rd(6, v); check("R3", v, 8'h24);

      // R4: February in leap and non-leap years
      day_roll("R4", 20, 24, 2, 28, 29, 2);
      day_roll("R4", 20, 24, 2, 29, 1, 3);
      day_roll("R4", 20, 23, 2, 28, 1, 3);
      day_roll("R4", 20, 0, 2, 28, 29, 2);
      day_roll("R4", 21, 0, 2, 28, 1, 3);

      // R5 and R2: year 99 to 00 carries into the century, weekday 7 to 1
      set_time(20, 99, 12, 31, 7, 23, 59, 59);
      run(P, 0);
      rd(7, v); check("R5", v, 8'h21);
      rd(6, v); check("R5", v, 8'h00);
      rd(3, v); check("R2", v, 8'h01);
      set_time(99, 99, 12, 31, 2, 23, 59, 59);
      run(P, 0);
      rd(7, v); check("R5", v, 8'h00);
      rd(3, v); check("R2", v, 8'h03);

      // R8: one-shot alarm on 15th at 08:10:05
      step(1, 1, 8, 8'h05); step(1, 1, 9, 8'h10);
      step(1, 1, 10, 8'h08); step(1, 1, 11, 8'h15);
      set_time(20, 25, 3, 15, 6, 8, 10, 0);
      hit_cnt = 0;
      run(10 * P, 0);
      check("R8", hit_cnt, 1);

      // R9: every field ignored -> once per second
      step(1, 1, 8, 8'h80); step(1, 1, 9, 8'h80);
      step(1, 1, 10, 8'h80); step(1, 1, 11, 8'h80);
      set_time(20, 25, 3, 15, 6, 0, 0, 0);
      hit_cnt = 0;
      run(5 * P, 0);
      check("R9", hit_cnt, 5);

      // R9: alarm write that matches the present time raises nothing
      step(0, 1, 8, 8'h05);
      check("R9", int'(alarm_hit), 0);

      // R9: only seconds compared -> once per minute
      step(1, 1, 8, 8'h30);
      set_time(20, 25, 3, 15, 6, 0, 0, 0);
      hit_cnt = 0;
      run(130 * P, 0);
      check("R9", hit_cnt, 2);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule